// File: doc/BRIEF.md
# Low-Power Standby Controller

This block moves a small processor core between running, light sleep and deep sleep, and brings it back. A wait-for-interrupt strobe from the core starts entry. A select bit chooses between light and deep sleep. A deep request is honoured only while the core runs from the main system clock. Otherwise the block drops into light sleep. In light sleep only the CPU clock gate is closed. In deep sleep the oscillator-stop enable is raised as well. The block never resets any state of the core; it only gates clocks.

While the core sleeps, the block watches the per-source interrupt requests against their mask bits and a global accept enable. The first unmasked, acceptable request releases the mode and sets a sticky release flag that software must clear. The block then counts a fixed wake latency on its always-on clock. At terminal count it reopens the CPU clock gate and sends a one-cycle wake strobe to the core. A combined reset input overrides everything and returns the block to run.

There is no streaming data path. Every pin is a plain control or status level, sampled or driven on the rising edge of the always-on clock, and there is no back-pressure.

Top module: `stby_ctrl`

## Requirements
- R1: A `wfi_i` pulse while running, with `deep_sel_i` at 0, enters light sleep. From the next cycle `cpu_clk_en_o` is 0 and `osc_stop_o` stays 0.
- R2: A `wfi_i` pulse while running, with `deep_sel_i` at 1 and `clk_is_main_i` at 1, enters deep sleep. From the next cycle `cpu_clk_en_o` is 0 and `osc_stop_o` is 1.
- R3: A deep request made while `clk_is_main_i` is 0 enters light sleep instead, so `osc_stop_o` stays 0.
- R4: While sleeping, the mode is released on the first edge where some source i has `irq_req_i[i]`=1 and `irq_mask_i[i]`=0 while `irq_en_i`=1. Requests that are masked, or that arrive while `irq_en_i` is 0, leave the core asleep. On release, `osc_stop_o` falls in the next cycle.
- R5: `wake_o` is high for exactly one cycle. It appears 16 cycles (WAKE_CYCLES) after the cycle in which `rel_flag_o` is first shown for that release. `cpu_clk_en_o` returns to 1 in that same cycle.
- R6: `rel_flag_o` is set by each release and then holds until `rel_clr_i` is sampled high. A release and a clear on the same edge leave the flag set.
- R7: `osc_stop_o` is 1 only in deep sleep and is never 1 while `cpu_clk_en_o` is 1.
- R8: If an unmasked, acceptable request is already pending when `wfi_i` is sampled, the block sleeps for one cycle and releases on the next edge. `wake_o` then comes 17 cycles after the edge that took the strobe.
- R9: `rst_i` (active high, synchronous) wins over everything. The next cycle shows `cpu_clk_en_o`=1 with `osc_stop_o`, `wake_o` and `rel_flag_o` all 0, and any wake count in progress is abandoned without a strobe.
- R10: `wfi_i` is ignored while sleeping or waking. Interrupt requests are ignored while running or waking and do not set `rel_flag_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_i | input | 1 | Combined reset from all reset sources, active high |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the core |
| deep_sel_i | input | 1 | 1 selects deep sleep for the next entry |
| clk_is_main_i | input | 1 | 1 while the CPU clock is the main system clock |
| irq_req_i | input | NUM_IRQ | Per-source interrupt requests |
| irq_mask_i | input | NUM_IRQ | Per-source masks, 1 blocks the source |
| irq_en_i | input | 1 | Core may accept interrupts |
| rel_clr_i | input | 1 | Software clear of the release flag |
| cpu_clk_en_o | output | 1 | CPU clock-gate enable |
| osc_stop_o | output | 1 | Oscillator-stop enable (deep sleep) |
| wake_o | output | 1 | One-cycle strobe: start interrupt service |
| rel_flag_o | output | 1 | Sticky standby-release flag |

## Verification
A state register stuck or mis-coded shows up within one cycle as a wrong `cpu_clk_en_o`/`osc_stop_o` pair, because those pins are direct decodes of the mode. A wake counter off by one, or not cleared, moves or drops `wake_o` and the reopening of the clock gate. A bench that counts cycles from the release sees this exactly 16 cycles after the flag rises. A release flag that fails to hold shows as a falling `rel_flag_o` in some cycle without a clear. A detector that ignores the mask or the enable shows as an early rise of `rel_flag_o`.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DEEP  = 2'd2,
    ST_WAKE  = 2'd3
  } stby_state_e;
endpackage

// File: rtl/stby_wake_detect.sv
// Combines per-source requests, masks and the global accept enable
// into one release request.
module stby_wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               irq_en_i,
  output logic               wake_req_o
);
  logic [NUM_IRQ-1:0] live;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign live[i] = irq_req_i[i] & ~irq_mask_i[i];
  end

  assign wake_req_o = irq_en_i & (|live);
endmodule

// File: rtl/stby_wake_timer.sv
// Fixed-latency wake counter on the always-on clock.
module stby_wake_timer #(
  parameter int WAKE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_i,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst_i || start_i) begin
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/stby_fsm.sv
// Mode sequencer: run, light sleep, deep sleep, waking.
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_i,
  input  logic        wfi_i,
  input  logic        deep_sel_i,
  input  logic        clk_is_main_i,
  input  logic        wake_req_i,
  input  logic        timer_done_i,
  output stby_state_e state_o,
  output logic        release_o,
  output logic        wake_o
);
  stby_state_e state_q, state_d;
  logic        wake_q;

  assign release_o = ((state_q == ST_SLEEP) || (state_q == ST_DEEP)) && wake_req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_i) begin
          state_d = (deep_sel_i && clk_is_main_i) ? ST_DEEP : ST_SLEEP;
        end
      end
      ST_SLEEP, ST_DEEP: begin
        if (release_o) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (timer_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_q == ST_WAKE) && timer_done_i;
    end
  end

  assign state_o = state_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/stby_release_flag.sv
// Sticky release indication; a set beats a clear on the same edge.
module stby_release_flag (
  input  logic clk,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst_i)      flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int WAKE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_i,
  input  logic               wfi_i,
  input  logic               deep_sel_i,
  input  logic               clk_is_main_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [NUM_IRQ-1:0] irq_mask_i,
  input  logic               irq_en_i,
  input  logic               rel_clr_i,
  output logic               cpu_clk_en_o,
  output logic               osc_stop_o,
  output logic               wake_o,
  output logic               rel_flag_o
);
  stby_state_e state;
  logic        wake_req;
  logic        release_ev;
  logic        timer_done;

  stby_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
    .irq_req_i (irq_req_i),
    .irq_mask_i(irq_mask_i),
    .irq_en_i  (irq_en_i),
    .wake_req_o(wake_req)
  );

  stby_fsm u_fsm (
    .clk          (clk),
    .rst_i        (rst_i),
    .wfi_i        (wfi_i),
    .deep_sel_i   (deep_sel_i),
    .clk_is_main_i(clk_is_main_i),
    .wake_req_i   (wake_req),
    .timer_done_i (timer_done),
    .state_o      (state),
    .release_o    (release_ev),
    .wake_o       (wake_o)
  );

  stby_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_i  (rst_i),
    .start_i(release_ev),
    .run_i  (state == ST_WAKE),
    .done_o (timer_done)
  );

  stby_release_flag u_flag (
    .clk   (clk),
    .rst_i (rst_i),
    .set_i (release_ev),
    .clr_i (rel_clr_i),
    .flag_o(rel_flag_o)
  );

  assign cpu_clk_en_o = (state == ST_RUN);
  assign osc_stop_o   = (state == ST_DEEP);
endmodule

// File: rtl/stby_ctrl_checker.sv
module stby_ctrl_checker (
  input logic clk,
  input logic rst_i,
  input logic wfi_i,
  input logic clk_is_main_i,
  input logic rel_clr_i,
  input logic cpu_clk_en_o,
  input logic osc_stop_o,
  input logic wake_o,
  input logic rel_flag_o
);
  AST_SLEEP_ON_WFI: assert property (@(posedge clk) disable iff (rst_i)
    (cpu_clk_en_o && wfi_i) |=> !cpu_clk_en_o); // R1

  AST_DEEP_NEEDS_MAIN: assert property (@(posedge clk) disable iff (rst_i)
    $rose(osc_stop_o) |-> $past(clk_is_main_i)); // R3

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst_i)
    wake_o |=> !wake_o); // R5

  AST_WAKE_OPENS_GATE: assert property (@(posedge clk) disable iff (rst_i)
    wake_o |-> cpu_clk_en_o); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst_i)
    (rel_flag_o && !rel_clr_i) |=> rel_flag_o); // R6

  AST_OSC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst_i)
    osc_stop_o |-> !cpu_clk_en_o); // R7

  AST_RESET_TO_RUN: assert property (@(posedge clk)
    rst_i |=> (cpu_clk_en_o && !osc_stop_o && !wake_o && !rel_flag_o)); // R9
endmodule

bind stby_ctrl stby_ctrl_checker u_chk (
  .clk          (clk),
  .rst_i        (rst_i),
  .wfi_i        (wfi_i),
  .clk_is_main_i(clk_is_main_i),
  .rel_clr_i    (rel_clr_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .osc_stop_o   (osc_stop_o),
  .wake_o       (wake_o),
  .rel_flag_o   (rel_flag_o)
);

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;
  localparam int N  = 8;
  localparam int WC = 16;

  logic         clk = 1'b0;
  logic         rst_i = 1'b1;
  logic         wfi_i = 1'b0;
  logic         deep_sel_i = 1'b0;
  logic         clk_is_main_i = 1'b1;
  logic [N-1:0] irq_req_i = '0;
  logic [N-1:0] irq_mask_i = '1;
  logic         irq_en_i = 1'b1;
  logic         rel_clr_i = 1'b0;
  logic         cpu_clk_en_o, osc_stop_o, wake_o, rel_flag_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stby_ctrl #(.NUM_IRQ(N), .WAKE_CYCLES(WC)) uut (
    .clk(clk), .rst_i(rst_i), .wfi_i(wfi_i), .deep_sel_i(deep_sel_i),
    .clk_is_main_i(clk_is_main_i), .irq_req_i(irq_req_i),
    .irq_mask_i(irq_mask_i), .irq_en_i(irq_en_i), .rel_clr_i(rel_clr_i),
    .cpu_clk_en_o(cpu_clk_en_o), .osc_stop_o(osc_stop_o),
    .wake_o(wake_o), .rel_flag_o(rel_flag_o)
  );

  // Behavioural reference: 0 run, 1 light sleep, 2 deep sleep, 3 waking
  int mode = 0;
  int waited = 0;
  bit m_flag = 1'b0;
  bit m_wake = 1'b0;
  bit m_valid = 1'b0;

  always @(posedge clk) begin
    bit rel;
    rel = 1'b0;
    if (rst_i) begin
      mode = 0; waited = 0; m_flag = 1'b0; m_wake = 1'b0; m_valid = 1'b1;
    end else begin
      m_wake = 1'b0;
      if (mode == 0) begin
        if (wfi_i) mode = (deep_sel_i && clk_is_main_i) ? 2 : 1;
      end else if (mode == 1 || mode == 2) begin
        if (irq_en_i && ((irq_req_i & ~irq_mask_i) != 0)) begin
          mode = 3; waited = 0; rel = 1'b1;
        end
      end else begin
        waited++;
        if (waited == WC) begin mode = 0; m_wake = 1'b1; end
      end
      if (rel) m_flag = 1'b1;
      else if (rel_clr_i) m_flag = 1'b0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R1 clk gate model", cpu_clk_en_o, (mode == 0));
      chk("R7 osc stop model", osc_stop_o, (mode == 2));
      chk("R5 wake strobe model", wake_o, m_wake);
      chk("R6 release flag model", rel_flag_o, m_flag);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts cycles until wake_o; optionally pulses wfi at one count.
  task automatic measure(output int n, input int poke_at);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      wfi_i = (n == poke_at);
    end while (!wake_o && n < 40);
    wfi_i = 1'b0;
  endtask

  initial begin
    int n;
    step(3);
    chk("R9 reset clk_en", cpu_clk_en_o, 1);
    chk("R9 reset osc", osc_stop_o, 0);
    chk("R9 reset flag", rel_flag_o, 0);
    rst_i = 1'b0;
    step(2);

    // Light sleep, masked and disabled requests, release latency
    wfi_i = 1'b1; step(1); wfi_i = 1'b0;
    chk("R1 sleep gate", cpu_clk_en_o, 0);
    chk("R1 sleep osc", osc_stop_o, 0);
    irq_req_i = 8'h04; step(3);
    chk("R4 masked ignored", rel_flag_o, 0);
    irq_en_i = 1'b0; irq_mask_i = 8'hFB; step(3);
    chk("R4 disabled ignored", cpu_clk_en_o, 0);
    chk("R4 disabled no flag", rel_flag_o, 0);
    irq_en_i = 1'b1;
    measure(n, 0);
    chk("R5 latency", n, WC + 1);
    chk("R5 gate reopens", cpu_clk_en_o, 1);
    chk("R6 flag set", rel_flag_o, 1);
    irq_req_i = '0; irq_mask_i = '1;
    step(1);
    chk("R5 single pulse", wake_o, 0);
    step(4);
    chk("R6 sticky", rel_flag_o, 1);
    rel_clr_i = 1'b1; step(1); rel_clr_i = 1'b0;
    chk("R6 cleared", rel_flag_o, 0);

    // Deep sleep, release with simultaneous clear
    deep_sel_i = 1'b1; wfi_i = 1'b1; step(1); wfi_i = 1'b0;
    chk("R2 deep osc", osc_stop_o, 1);
    chk("R2 deep gate", cpu_clk_en_o, 0);
    step(2);
    irq_mask_i = 8'hFE; irq_req_i = 8'h01; rel_clr_i = 1'b1;
    step(1); rel_clr_i = 1'b0;
    chk("R6 set beats clear", rel_flag_o, 1);
    chk("R4 osc released", osc_stop_o, 0);
    measure(n, 0);
    chk("R5 deep latency", n, WC);
    irq_req_i = '0; irq_mask_i = '1;
    rel_clr_i = 1'b1; step(1); rel_clr_i = 1'b0;

    // Deep refused without main clock, wfi ignored in sleep and waking
    clk_is_main_i = 1'b0; wfi_i = 1'b1; step(1); wfi_i = 1'b0;
    chk("R3 fallback osc", osc_stop_o, 0);
    chk("R3 fallback gate", cpu_clk_en_o, 0);
    wfi_i = 1'b1; step(1); wfi_i = 1'b0; step(2);
    chk("R10 wfi in sleep", cpu_clk_en_o, 0);
    chk("R10 wfi in sleep osc", osc_stop_o, 0);
    irq_mask_i = 8'h7F; irq_req_i = 8'h80;
    measure(n, 5);
    chk("R10 wfi in waking", n, WC + 1);
    step(3);
    chk("R10 stays running", cpu_clk_en_o, 1);
    rel_clr_i = 1'b1; step(1); rel_clr_i = 1'b0; step(3);
    chk("R10 irq in run no flag", rel_flag_o, 0);
    irq_req_i = '0; irq_mask_i = '1; clk_is_main_i = 1'b1; deep_sel_i = 1'b0;

    // Pending request at entry bounces back
    irq_mask_i = 8'hFD; irq_req_i = 8'h02;
    wfi_i = 1'b1;
    measure(n, 0);
    chk("R8 bounce latency", n, WC + 2);
    irq_req_i = '0; irq_mask_i = '1;
    rel_clr_i = 1'b1; step(1); rel_clr_i = 1'b0;

    // Reset in the middle of a wake count
    wfi_i = 1'b1; step(1); wfi_i = 1'b0;
    irq_mask_i = 8'hEF; irq_req_i = 8'h10; step(6);
    irq_req_i = '0; irq_mask_i = '1;
    rst_i = 1'b1; step(1); rst_i = 1'b0;
    chk("R9 reset gate", cpu_clk_en_o, 1);
    chk("R9 reset flag clear", rel_flag_o, 0);
    n = 0;
    for (int i = 0; i < 25; i++) begin
      step(1);
      if (wake_o) n++;
    end
    chk("R9 no late strobe", n, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule